// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Period-Aligned Updates

This block generates four independent pulse-width modulated waveforms. Each channel has its own 16-bit up-counter clocked through a power-of-two prescaler, a duty threshold, a period length and an output polarity. Software controls the block through a simple register bus: a word address, write data, a write strobe and registered read data.

Channels are switched on and off through two global write-one registers, and a status register reports which channels are running. While a channel is stopped, software loads its duty and period directly. While it runs, those registers are locked, and new values go through a per-channel update register. The update register holds the value until the current period ends. A mode bit chooses whether the held value replaces the duty or the period. This lets a running waveform change without a truncated or stretched pulse.

Top module: `mpwm_top`

## Requirements
- R1: Writing 1 to bit n at address 0x004 starts channel n, and writing 1 to bit n at address 0x008 stops it. Zero bits leave channels unchanged. Bits [3:0] of address 0x00C read back which channels are running. All reads return data one clock after the address is presented.
- R2: Channel n's bank starts at 0x200 + n*0x20, with mode at +0x00, duty at +0x04, period at +0x08 and update at +0x10. The mode register reads back only bits [3:0], 9 and 10, and duty and period read back only bits [15:0]. Any other address, including the update register, reads zero. Writes to unmapped addresses change nothing.
- R3: Mode bits [3:0] select a prescaler exponent p, and the channel counter advances once every 2^p clocks. A value above 10 acts as 10.
- R4: A running counter steps 0, 1, ..., period-1 and then wraps to 0. A period of 0 or 1 keeps it at 0. One clock after each counter state, the non-inverted output is 1 exactly when count < duty. A duty at or above the period therefore gives a constant 1, and a duty of 0 gives a constant 0.
- R5: Mode bit 9 = 1 inverts the channel output, and bit 9 = 0 leaves it in the normal sense.
- R6: A stopped channel holds its counter and prescaler at 0 and drives its output to the value of mode bit 9. Starting a channel begins counting from 0. Writing 1 to the start register for a channel that is already running has no effect.
- R7: Direct writes to duty and period take effect only while the channel is stopped. While it runs they are ignored.
- R8: A write to the update register stores bits [15:0] as a pending value, together with the mode bit 10 in force at the time of that write (0 = duty, 1 = period). The pending value is copied into its target on the prescaler tick that ends the current period, and the pending state then clears. A later update write replaces an earlier one that has not yet been applied.
- R9: Synchronous active-high reset stops all channels, clears every register and drives all outputs and read data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for the address of the previous clock |
| pwm_out | output | 4 | Waveform outputs, bit n for channel n |

## Verification
On every cycle, the assertions check four things. A stopped channel's output matches its polarity. The counter stays below a non-zero period. Duty and period never move in the middle of a running period. A channel that starts does so at count 0. They also check that a status read returns the run mask of the cycle before. Only the bench's scenarios can show the prescaler division and the clamp at 10, the exact duty-cycle shape, and the delay of update writes to the period boundary with the latest write winning. The same holds for the decoding of holes and unmapped addresses and for the field masking on read-back. The bench covers these with a behavioural model that it compares on every clock, and with literal register and output checks.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int OFS_ENA     = 'h004;
  localparam int OFS_DIS     = 'h008;
  localparam int OFS_STAT    = 'h00C;
  localparam int BANK_BASE   = 'h200;
  localparam int BANK_STRIDE = 'h020;

  localparam logic [4:0] REG_MODE = 5'h00;
  localparam logic [4:0] REG_DUTY = 5'h04;
  localparam logic [4:0] REG_PRD  = 5'h08;
  localparam logic [4:0] REG_UPD  = 5'h10;

  localparam int PSEL_W  = 4;
  localparam int POL_BIT = 9;
  localparam int TGT_BIT = 10;
endpackage

// File: rtl/mpwm_regs.sv
module mpwm_regs
  import mpwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int CW  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [AW-1:0]           bus_addr,
  input  logic [DW-1:0]           bus_wdata,
  input  logic                    bus_we,
  input  logic [NCH-1:0][DW-1:0]  mode_rd,
  input  logic [NCH-1:0][CW-1:0]  duty_rd,
  input  logic [NCH-1:0][CW-1:0]  prd_rd,
  output logic [NCH-1:0]          en_q,
  output logic [NCH-1:0]          wr_mode,
  output logic [NCH-1:0]          wr_duty,
  output logic [NCH-1:0]          wr_prd,
  output logic [NCH-1:0]          wr_upd,
  output logic [DW-1:0]           rdata
);
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SPAN = NCH * BANK_STRIDE;

  logic [AW-1:0] rel;
  logic          in_bank;
  logic [IW-1:0] idx;
  logic [4:0]    ofs;
  logic [DW-1:0] rd_next;

  assign rel     = bus_addr - AW'(BANK_BASE);
  assign in_bank = (bus_addr >= AW'(BANK_BASE)) && (int'(rel) < SPAN);
  assign idx     = rel[5 +: IW];
  assign ofs     = rel[4:0];

  // run mask: set and clear registers, one bit per channel
  always_ff @(posedge clk) begin
    if (rst)
      en_q <= '0;
    else if (bus_we && bus_addr == AW'(OFS_ENA))
      en_q <= en_q | bus_wdata[NCH-1:0];
    else if (bus_we && bus_addr == AW'(OFS_DIS))
      en_q <= en_q & ~bus_wdata[NCH-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic hit;
    assign hit        = bus_we && in_bank && (idx == IW'(i));
    assign wr_mode[i] = hit && (ofs == REG_MODE);
    assign wr_duty[i] = hit && (ofs == REG_DUTY) && !en_q[i];
    assign wr_prd[i]  = hit && (ofs == REG_PRD)  && !en_q[i];
    assign wr_upd[i]  = hit && (ofs == REG_UPD);
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == AW'(OFS_STAT))
      rd_next[NCH-1:0] = en_q;
    else if (in_bank) begin
      case (ofs)
        REG_MODE: rd_next           = mode_rd[idx];
        REG_DUTY: rd_next[CW-1:0]   = duty_rd[idx];
        REG_PRD:  rd_next[CW-1:0]   = prd_rd[idx];
        default:  rd_next           = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan
  import mpwm_pkg::*;
#(
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int PMAX = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] wdata,
  input  logic          wr_mode,
  input  logic          wr_duty,
  input  logic          wr_prd,
  input  logic          wr_upd,
  output logic [DW-1:0] mode_word,
  output logic [CW-1:0] duty_q,
  output logic [CW-1:0] prd_q,
  output logic [CW-1:0] cnt_q,
  output logic          pol_q,
  output logic          pwm_o
);
  localparam int DIVW = PMAX + 1;

  logic [PSEL_W-1:0] pres_q, p_eff;
  logic              tgt_q;
  logic [DIVW-1:0]   div_q, lim;
  logic              tick, end_per, apply;
  logic              pend_q, ptgt_q;
  logic [CW-1:0]     pval_q;

  assign p_eff   = (pres_q > PSEL_W'(PMAX)) ? PSEL_W'(PMAX) : pres_q;
  assign lim     = (DIVW'(1) << p_eff) - DIVW'(1);
  assign tick    = (div_q >= lim);
  assign end_per = ({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, prd_q};
  assign apply   = en && tick && end_per && pend_q;

  always_comb begin
    mode_word                = '0;
    mode_word[PSEL_W-1:0]    = pres_q;
    mode_word[POL_BIT]       = pol_q;
    mode_word[TGT_BIT]       = tgt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pres_q <= '0;
      pol_q  <= 1'b0;
      tgt_q  <= 1'b0;
      div_q  <= '0;
      cnt_q  <= '0;
      duty_q <= '0;
      prd_q  <= '0;
      pend_q <= 1'b0;
      ptgt_q <= 1'b0;
      pval_q <= '0;
      pwm_o  <= 1'b0;
    end else begin
      if (wr_mode) begin
        pres_q <= wdata[PSEL_W-1:0];
        pol_q  <= wdata[POL_BIT];
        tgt_q  <= wdata[TGT_BIT];
      end

      if (!en) begin
        div_q <= '0;
        cnt_q <= '0;
      end else if (tick) begin
        div_q <= '0;
        cnt_q <= end_per ? '0 : cnt_q + CW'(1);
      end else begin
        div_q <= div_q + DIVW'(1);
      end

      if (wr_duty)                duty_q <= wdata[CW-1:0];
      else if (apply && !ptgt_q)  duty_q <= pval_q;

      if (wr_prd)                 prd_q <= wdata[CW-1:0];
      else if (apply && ptgt_q)   prd_q <= pval_q;

      if (wr_upd) begin
        pend_q <= 1'b1;
        pval_q <= wdata[CW-1:0];
        ptgt_q <= tgt_q;
      end else if (apply) begin
        pend_q <= 1'b0;
      end

      pwm_o <= pol_q ^ (en && (cnt_q < duty_q));
    end
  end
endmodule

// File: rtl/mpwm_top.sv
module mpwm_top #(
  parameter int NCH  = 4,
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int PMAX = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  input  logic           bus_we,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  logic [NCH-1:0]          en_v, pol_v;
  logic [NCH-1:0]          wr_mode, wr_duty, wr_prd, wr_upd;
  logic [NCH-1:0][DW-1:0]  mode_v;
  logic [NCH-1:0][CW-1:0]  duty_v, prd_v, cnt_v;

  mpwm_regs #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .mode_rd  (mode_v),
    .duty_rd  (duty_v),
    .prd_rd   (prd_v),
    .en_q     (en_v),
    .wr_mode  (wr_mode),
    .wr_duty  (wr_duty),
    .wr_prd   (wr_prd),
    .wr_upd   (wr_upd),
    .rdata    (bus_rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    mpwm_chan #(.DW(DW), .CW(CW), .PMAX(PMAX)) chan_i (
      .clk      (clk),
      .rst      (rst),
      .en       (en_v[i]),
      .wdata    (bus_wdata),
      .wr_mode  (wr_mode[i]),
      .wr_duty  (wr_duty[i]),
      .wr_prd   (wr_prd[i]),
      .wr_upd   (wr_upd[i]),
      .mode_word(mode_v[i]),
      .duty_q   (duty_v[i]),
      .prd_q    (prd_v[i]),
      .cnt_q    (cnt_v[i]),
      .pol_q    (pol_v[i]),
      .pwm_o    (pwm_out[i])
    );
  end
endmodule

// File: rtl/mpwm_chk.sv
module mpwm_chk #(
  parameter int NCH = 4,
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int CW  = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [AW-1:0]          bus_addr,
  input logic                   bus_we,
  input logic [DW-1:0]          bus_rdata,
  input logic [NCH-1:0]         pwm_out,
  input logic [NCH-1:0]         en_v,
  input logic [NCH-1:0]         pol_v,
  input logic [NCH-1:0][CW-1:0] cnt_v,
  input logic [NCH-1:0][CW-1:0] duty_v,
  input logic [NCH-1:0][CW-1:0] prd_v
);
  // R1
  status_rd_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!bus_we && bus_addr == AW'('h00C)) |->
      bus_rdata == {{(DW-NCH){1'b0}}, $past(en_v)});

  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    ((pwm_out ^ $past(pol_v)) & ~$past(en_v)) == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
      (prd_v[i] != '0) |-> (cnt_v[i] < prd_v[i]));

    // R6
    start_zero_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(en_v[i]) |-> (cnt_v[i] == '0));

    // R8
    midperiod_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(en_v[i]) && en_v[i] && cnt_v[i] != '0) |->
        ($stable(duty_v[i]) && $stable(prd_v[i])));
  end
endmodule

bind mpwm_top mpwm_chk #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_rdata(bus_rdata),
  .pwm_out  (pwm_out),
  .en_v     (en_v),
  .pol_v    (pol_v),
  .cnt_v    (cnt_v),
  .duty_v   (duty_v),
  .prd_v    (prd_v)
);

// File: tb/mpwm_top_tb_top.sv
module mpwm_top_tb_top;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_req = "R9";

  always #10 clk = ~clk;

  mpwm_top dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // behavioural reference state
  int m_en[NCH], m_pres[NCH], m_pol[NCH], m_tgt[NCH];
  int m_duty[NCH], m_prd[NCH], m_cnt[NCH], m_div[NCH];
  int m_pend[NCH], m_pval[NCH], m_ptgt[NCH], m_out[NCH];
  int m_rdata;

  function automatic int model_read(int a);
    int base, ofs, c;
    if (a == 'h00C) return m_en[0] | (m_en[1] << 1) | (m_en[2] << 2) | (m_en[3] << 3);
    if (a < 'h200 || a >= 'h200 + NCH * 'h20) return 0;
    base = a - 'h200;
    c = base / 'h20;
    ofs = base % 'h20;
    case (ofs)
      'h00: return m_pres[c] | (m_pol[c] << 9) | (m_tgt[c] << 10);
      'h04: return m_duty[c];
      'h08: return m_prd[c];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_en[c] = 0; m_pres[c] = 0; m_pol[c] = 0; m_tgt[c] = 0;
        m_duty[c] = 0; m_prd[c] = 0; m_cnt[c] = 0; m_div[c] = 0;
        m_pend[c] = 0; m_pval[c] = 0; m_ptgt[c] = 0; m_out[c] = 0;
      end
      m_rdata = 0;
    end else begin
      m_rdata = model_read(int'(bus_addr));
      for (int c = 0; c < NCH; c++)
        m_out[c] = m_pol[c] ^ ((m_en[c] != 0 && m_cnt[c] < m_duty[c]) ? 1 : 0);
      for (int c = 0; c < NCH; c++) begin
        int pe, lim, ofs, old_tgt;
        bit tick, endp, app, hit;
        old_tgt = m_tgt[c];
        pe   = (m_pres[c] > 10) ? 10 : m_pres[c];
        lim  = (1 << pe) - 1;
        tick = (m_div[c] >= lim);
        endp = (m_cnt[c] + 1 >= m_prd[c]);
        app  = (m_en[c] != 0) && tick && endp && (m_pend[c] != 0);
        hit  = bus_we && (int'(bus_addr) >= 'h200 + c * 'h20) &&
               (int'(bus_addr) < 'h220 + c * 'h20);
        ofs  = int'(bus_addr) - ('h200 + c * 'h20);
        if (m_en[c] == 0) begin
          m_div[c] = 0; m_cnt[c] = 0;
        end else if (tick) begin
          m_div[c] = 0; m_cnt[c] = endp ? 0 : m_cnt[c] + 1;
        end else begin
          m_div[c] = m_div[c] + 1;
        end
        if (app) begin
          if (m_ptgt[c] != 0) m_prd[c] = m_pval[c];
          else                m_duty[c] = m_pval[c];
        end
        if (hit && ofs == 'h04 && m_en[c] == 0) m_duty[c] = int'(bus_wdata[15:0]);
        if (hit && ofs == 'h08 && m_en[c] == 0) m_prd[c]  = int'(bus_wdata[15:0]);
        if (hit && ofs == 'h10) begin
          m_pend[c] = 1; m_pval[c] = int'(bus_wdata[15:0]); m_ptgt[c] = old_tgt;
        end else if (app) begin
          m_pend[c] = 0;
        end
        if (hit && ofs == 'h00) begin
          m_pres[c] = int'(bus_wdata[3:0]);
          m_pol[c]  = int'(bus_wdata[9]);
          m_tgt[c]  = int'(bus_wdata[10]);
        end
      end
      if (bus_we && bus_addr == 12'h004)
        for (int c = 0; c < NCH; c++) if (bus_wdata[c]) m_en[c] = 1;
      if (bus_we && bus_addr == 12'h008)
        for (int c = 0; c < NCH; c++) if (bus_wdata[c]) m_en[c] = 0;
    end
  end

  // cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int c = 0; c < NCH; c++) begin
        checks++;
        if (int'(pwm_out[c]) != m_out[c]) begin
          fails++;
          $display("FAIL %s: pwm_out[%0d] actual %0d expected %0d at %0t",
                   cur_req, c, pwm_out[c], m_out[c], $time);
        end
      end
      checks++;
      if (int'(bus_rdata) != m_rdata) begin
        fails++;
        $display("FAIL %s: bus_rdata actual %h expected %h at %0t",
                 cur_req, bus_rdata, m_rdata, $time);
      end
    end
  end

  task automatic expect_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_addr = 12'(a); bus_wdata = 32'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 12'h000; bus_wdata = '0;
  endtask

  task automatic rd_expect(string req, int a, int exp);
    @(negedge clk);
    bus_addr = 12'(a); bus_we = 1'b0;
    @(negedge clk);
    expect_eq(req, int'(bus_rdata), exp);
    bus_addr = 12'h000;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    expect_eq("R9", int'(pwm_out), 0);
    expect_eq("R9", int'(bus_rdata), 0);
    rd_expect("R9", 'h00C, 0);

    // R2 unmapped and holes
    cur_req = "R2";
    wr('h000, 'hF);
    rd_expect("R2", 'h00C, 0);
    rd_expect("R2", 'h010, 0);
    rd_expect("R2", 'h20C, 0);
    rd_expect("R2", 'h280, 0);
    wr('h264, 'hABCD1234);
    rd_expect("R2", 'h264, 'h1234);
    wr('h260, -1);
    rd_expect("R2", 'h260, 'h60F);
    rd_expect("R8", 'h210, 0);

    // R4 channel 0: p=0, duty 3, period 8
    cur_req = "R4";
    wr('h200, 0);
    wr('h204, 3);
    wr('h208, 8);
    rd_expect("R4", 'h204, 3);
    wr('h004, 'h1);
    rd_expect("R1", 'h00C, 1);
    idle(40);

    // R3 / R5 channel 1: p=2, duty 2, period 4, inverted
    cur_req = "R3";
    wr('h220, 'h202);
    wr('h224, 2);
    wr('h228, 4);
    wr('h004, 'h2);
    idle(60);

    // R1 zero bits change nothing
    cur_req = "R1";
    wr('h004, 0);
    wr('h008, 0);
    rd_expect("R1", 'h00C, 3);

    // R7 direct writes ignored while running
    cur_req = "R7";
    wr('h204, 7);
    wr('h208, 20);
    rd_expect("R7", 'h204, 3);
    rd_expect("R7", 'h208, 8);

    // R8 duty update, last write wins, then period update
    cur_req = "R8";
    wr('h210, 5);
    wr('h210, 6);
    idle(20);
    rd_expect("R8", 'h204, 6);
    wr('h200, 'h400);
    rd_expect("R2", 'h200, 'h400);
    wr('h210, 12);
    idle(30);
    rd_expect("R8", 'h208, 12);
    rd_expect("R8", 'h204, 6);
    idle(30);

    // R4 full and empty duty on channel 2
    cur_req = "R4";
    wr('h244, 9);
    wr('h248, 5);
    wr('h004, 'h4);
    idle(20);
    expect_eq("R4", int'(pwm_out[2]), 1);
    wr('h008, 'h4);
    wr('h244, 0);
    wr('h004, 'h4);
    idle(20);
    expect_eq("R4", int'(pwm_out[2]), 0);
    wr('h008, 'h4);
    wr('h248, 0);
    wr('h244, 1);
    wr('h004, 'h4);
    idle(20);
    expect_eq("R4", int'(pwm_out[2]), 1);

    // R6 stop channel 1 (inverted): output holds its polarity, restart at 0
    cur_req = "R6";
    wr('h008, 'h2);
    idle(3);
    expect_eq("R6", int'(pwm_out[1]), 1);
    rd_expect("R6", 'h00C, 'h5);
    wr('h004, 'h2);
    idle(17);
    wr('h004, 'h2);
    idle(20);

    // R3 clamp: channel 3 exponent 15 acts as 10, period 2 duty 1
    cur_req = "R3";
    wr('h260, 'h00F);
    wr('h264, 1);
    wr('h268, 2);
    wr('h004, 'h8);
    idle(500);
    expect_eq("R3", int'(pwm_out[3]), 1);
    idle(600);
    expect_eq("R3", int'(pwm_out[3]), 0);
    idle(1100);
    expect_eq("R3", int'(pwm_out[3]), 1);
    idle(50);

    // R9 reset mid-run
    cur_req = "R9";
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expect_eq("R9", int'(pwm_out), 0);
    rd_expect("R9", 'h00C, 0);
    idle(5);
    finish_run();
  end
endmodule